// File: doc/BRIEF.md
# CAN Controller Mode Handshake and Bit-Timing Configuration

This block holds the operating-mode controls and the configuration registers of a CAN controller. Software writes request bits for initialization or sleep into an always-writable control register. The block grants a request only while the protocol engine reports the bus idle. It confirms entry by raising a matching acknowledge flag, and a mode counts as active only while both its request and its acknowledge are set. In sleep, an optional wake-up enable lets bus activity end the sleep without software help.

While initialization mode is active, the block unlocks writes to twenty protected configuration bytes. These are an auxiliary control byte, two timing bytes, an acceptance-control byte, eight acceptance-code bytes and eight acceptance-mask bytes. Outside that mode, writes to them are dropped. The first timing byte carries a resynchronization jump-width code and a baud prescaler. From these the block produces a time-quantum clock enable and the decoded jump width in time quanta.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset both acknowledge flags are 0, and every register address 0 to 23 reads 0x00.
- R2: Address 0 bit 0 requests initialization. `init_ack` rises on the second clock edge after the write when `bus_idle` is 1, and it stays 0 for as long as `bus_idle` is 0.
- R3: Once the request bit is cleared, the acknowledge for that mode falls at the next clock edge after the request register changes.
- R4: Address 0 bit 1 requests sleep. `sleep_ack` rises under the same idle-gated, one-cycle handshake as initialization.
- R5: While sleep is acknowledged and the wake-enable bit (address 0 bit 2) is 1, `bus_activity` clears `sleep_ack` at the next edge. The flag then stays 0 until the sleep request is removed and set again. When wake-enable is 0, bus activity has no effect on `sleep_ack`.
- R6: Initialization has priority over sleep. While the initialization request is set, `sleep_ack` is 0, and a sleep that is already in progress ends at the next edge.
- R7: The protected addresses are 2 to 5, 8 to 15 and 16 to 23. They accept writes only while the initialization request and `init_ack` are both 1. A write at any other time leaves the stored value unchanged.
- R8: Address 0 reads back its three request and enable bits. Address 1 is read-only, with bit 0 = `init_ack` and bit 1 = `sleep_ack`. Timing byte 0 sits at address 3 and reads back at any time.
- R9: `sjw_tq` equals the jump-width code in bits 7:6 of address 3, plus one. Codes 00, 01, 10 and 11 give 1, 2, 3 and 4 quanta.
- R10: Outside initialization mode, `tq_en` pulses once every (P+1) clocks, where P is the prescaler in bits 5:0 of address 3. While initialization mode is active, `tq_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| bus_idle | input | 1 | Protocol engine reports the bus idle |
| bus_activity | input | 1 | Protocol engine sees activity on the bus |
| init_ack | output | 1 | Initialization mode acknowledged |
| sleep_ack | output | 1 | Sleep mode acknowledged |
| cfg_unlocked | output | 1 | Initialization mode active; protected writes allowed |
| tq_en | output | 1 | Time-quantum clock enable pulse |
| sjw_tq | output | 3 | Jump width in time quanta (1 to 4) |

## Verification
A request write lands in its register at the write edge, and the acknowledge follows one edge later. The bench therefore samples acknowledges at the second falling edge after it drives a write. Wake-up and priority effects appear at the first edge after their cause, and the bench checks them at the following falling edge. Reads are combinational, so each read is sampled a moment after the address settles. The bench sweeps the prescaler over all 64 values and checks each with a measured pulse spacing. Every protected address is written both unlocked and locked, and the bench checks each one by reading it back.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int NPROT   = 20;
    localparam int BRP_W   = 6;
    localparam int SJW_W   = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 5'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 5'd1;
    localparam int TIM0_SLOT = 1;

    // slots 0..3 live at 2..5, slots 4..19 at 8..23
    function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
        int a;
        a = (idx < 4) ? idx + 2 : idx + 4;
        return a[ADDR_W-1:0];
    endfunction

    typedef struct packed {
        logic init_ack;
        logic sleep_ack;
        logic woke;
    } mode_st_t;

endpackage

// File: rtl/can_mode_hs.sv
module can_mode_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic init_req,
    input  logic sleep_req,
    input  logic wake_en,
    input  logic bus_idle,
    input  logic bus_activity,
    output logic init_ack,
    output logic sleep_ack,
    output logic cfg_unlocked
);
    import can_mode_pkg::*;

    mode_st_t st_d, st_q;
    logic wake_hit;

    always_comb begin
        st_d = st_q;
        wake_hit = st_q.sleep_ack & wake_en & bus_activity;
        // acknowledge granted only on an idle bus, dropped with the request
        st_d.init_ack = init_req & (st_q.init_ack | bus_idle);
        // woken sleep stays blocked until the request is withdrawn
        st_d.woke = sleep_req & (st_q.woke | wake_hit);
        if (!sleep_req || init_req || st_q.woke) begin
            st_d.sleep_ack = 1'b0;
        end else if (st_q.sleep_ack) begin
            st_d.sleep_ack = ~wake_hit;
        end else begin
            st_d.sleep_ack = bus_idle;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign init_ack     = st_q.init_ack;
    assign sleep_ack    = st_q.sleep_ack;
    assign cfg_unlocked = init_req & st_q.init_ack;

endmodule

// File: rtl/can_cfg_bank.sv
module can_cfg_bank (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               reg_wr,
    input  logic [can_mode_pkg::ADDR_W-1:0]    reg_addr,
    input  logic [can_mode_pkg::DATA_W-1:0]    reg_wdata,
    input  logic                               unlocked,
    input  logic                               init_ack,
    input  logic                               sleep_ack,
    output logic [can_mode_pkg::DATA_W-1:0]    reg_rdata,
    output logic                               init_req,
    output logic                               sleep_req,
    output logic                               wake_en,
    output logic [can_mode_pkg::DATA_W-1:0]    tim0
);
    import can_mode_pkg::*;

    typedef struct packed {
        logic [2:0]                    ctrl;
        logic [NPROT-1:0][DATA_W-1:0]  prot;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NPROT-1:0] hit;

    for (genvar g = 0; g < NPROT; g++) begin : g_slot
        assign hit[g] = (reg_addr == slot_addr(g));
    end

    always_comb begin
        bank_d = bank_q;
        if (reg_wr && reg_addr == A_CTRL) begin
            bank_d.ctrl = reg_wdata[2:0];
        end
        for (int i = 0; i < NPROT; i++) begin
            if (reg_wr && unlocked && hit[i]) begin
                bank_d.prot[i] = reg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            reg_rdata = {5'd0, bank_q.ctrl};
        end else if (reg_addr == A_STATUS) begin
            reg_rdata = {6'd0, sleep_ack, init_ack};
        end
        for (int i = 0; i < NPROT; i++) begin
            if (hit[i]) begin
                reg_rdata = bank_q.prot[i];
            end
        end
    end

    assign init_req  = bank_q.ctrl[0];
    assign sleep_req = bank_q.ctrl[1];
    assign wake_en   = bank_q.ctrl[2];
    assign tim0      = bank_q.prot[TIM0_SLOT];

endmodule

// File: rtl/can_tq_gen.sv
module can_tq_gen #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [BRP_W-1:0] brp,
    output logic             tq_en
);
    typedef struct packed {
        logic [BRP_W-1:0] cnt;
    } tq_st_t;

    tq_st_t st_d, st_q;
    logic at_end;

    always_comb begin
        st_d = st_q;
        at_end = (st_q.cnt == brp);
        if (hold || at_end) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tq_en = at_end & ~hold;

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [4:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       bus_idle,
    input  logic       bus_activity,
    output logic       init_ack,
    output logic       sleep_ack,
    output logic       cfg_unlocked,
    output logic       tq_en,
    output logic [2:0] sjw_tq
);
    import can_mode_pkg::*;

    logic        init_req, sleep_req, wake_en;
    logic [DATA_W-1:0] tim0;

    can_cfg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .unlocked  (cfg_unlocked),
        .init_ack  (init_ack),
        .sleep_ack (sleep_ack),
        .reg_rdata (reg_rdata),
        .init_req  (init_req),
        .sleep_req (sleep_req),
        .wake_en   (wake_en),
        .tim0      (tim0)
    );

    can_mode_hs u_hs (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_req     (init_req),
        .sleep_req    (sleep_req),
        .wake_en      (wake_en),
        .bus_idle     (bus_idle),
        .bus_activity (bus_activity),
        .init_ack     (init_ack),
        .sleep_ack    (sleep_ack),
        .cfg_unlocked (cfg_unlocked)
    );

    can_tq_gen #(.BRP_W(BRP_W)) u_tq (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (cfg_unlocked),
        .brp   (tim0[BRP_W-1:0]),
        .tq_en (tq_en)
    );

    assign sjw_tq = {1'b0, tim0[DATA_W-1 -: SJW_W]} + 3'd1;

endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       bus_idle,
    input logic       bus_activity,
    input logic       init_ack,
    input logic       sleep_ack,
    input logic       cfg_unlocked,
    input logic       tq_en,
    input logic       init_req,
    input logic       sleep_req,
    input logic       wake_en,
    input logic [7:0] tim0
);
    p_init_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_ack) |-> $past(init_req) && $past(bus_idle));

    p_init_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !init_req |=> !init_ack);

    p_sleep_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_ack) |-> $past(sleep_req) && $past(bus_idle));

    p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_ack && wake_en && bus_activity) |=> !sleep_ack);

    p_sleep_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_ack && sleep_req && !init_req && !wake_en) |=> sleep_ack);

    p_init_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> !sleep_ack);

    p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_unlocked |=> $stable(tim0));

    p_tq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_unlocked |-> !tq_en);

    p_tq_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_en && tim0[5:0] != 6'd0 && !reg_wr) |=> !tq_en);

endmodule

bind can_mode_ctrl can_mode_ctrl_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .bus_idle     (bus_idle),
    .bus_activity (bus_activity),
    .init_ack     (init_ack),
    .sleep_ack    (sleep_ack),
    .cfg_unlocked (cfg_unlocked),
    .tq_en        (tq_en),
    .init_req     (init_req),
    .sleep_req    (sleep_req),
    .wake_en      (wake_en),
    .tim0         (tim0)
);

// File: tb/test_can_mode_ctrl.sv
module test_can_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       bus_idle = 1'b1;
    logic       bus_activity = 1'b0;
    logic       init_ack, sleep_ack, cfg_unlocked, tq_en;
    logic [2:0] sjw_tq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    can_mode_ctrl i_can_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_idle(bus_idle),
        .bus_activity(bus_activity), .init_ack(init_ack), .sleep_ack(sleep_ack),
        .cfg_unlocked(cfg_unlocked), .tq_en(tq_en), .sjw_tq(sjw_tq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [4:0] paddr(input int i);
        int a;
        a = (i < 4) ? i + 2 : i + 4;
        return a[4:0];
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(init_ack == 0 && sleep_ack == 0, "R1", {init_ack, sleep_ack}, 0);
        for (int a = 0; a < 24; a++) begin
            rd(a[4:0], v);
            chk(v == 8'h00, "R1", v, 0);
        end

        // R8 control readback, timing byte at reset
        wr(5'd0, 8'h04);
        rd(5'd0, v); chk(v == 8'h04, "R8", v, 8'h04);
        wr(5'd0, 8'h00);
        rd(5'd3, v); chk(v == 8'h00, "R8", v, 0);

        // R2 initialization waits for idle bus
        bus_idle = 1'b0;
        wr(5'd0, 8'h01);
        for (int k = 0; k < 3; k++) begin
            chk(init_ack == 0, "R2", init_ack, 0);
            @(negedge clk);
        end
        bus_idle = 1'b1;
        @(negedge clk);
        chk(init_ack == 1, "R2", init_ack, 1);
        rd(5'd1, v); chk(v == 8'h01, "R8", v, 8'h01);

        // R10 tq_en held while initialization active
        n = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (tq_en) n++;
        end
        chk(n == 0, "R10", n, 0);

        // R7 unlocked writes to every protected byte
        for (int i = 0; i < 20; i++) wr(paddr(i), 8'((i * 37 + 5) & 8'hff));
        for (int i = 0; i < 20; i++) begin
            rd(paddr(i), v);
            chk(v == 8'((i * 37 + 5) & 8'hff), "R7", v, (i * 37 + 5) & 8'hff);
        end

        // R3 leave initialization
        wr(5'd0, 8'h00);
        @(negedge clk);
        chk(init_ack == 0, "R3", init_ack, 0);

        // R7 locked writes are ignored
        for (int i = 0; i < 20; i++) wr(paddr(i), 8'(~((i * 37 + 5) & 8'hff)));
        for (int i = 0; i < 20; i++) begin
            rd(paddr(i), v);
            chk(v == 8'((i * 37 + 5) & 8'hff), "R7", v, (i * 37 + 5) & 8'hff);
        end

        // R8 R9 R10 prescaler and jump-width sweep
        for (int p = 0; p < 64; p++) begin
            logic [7:0] t;
            t = {2'(p & 3), 6'(p)};
            wr(5'd0, 8'h01);
            @(negedge clk);
            wr(5'd3, t);
            wr(5'd0, 8'h00);
            rd(5'd3, v); chk(v == t, "R8", v, t);
            chk(sjw_tq == 3'((p & 3) + 1), "R9", sjw_tq, (p & 3) + 1);
            n = 0;
            while (!tq_en && n < 200) begin @(negedge clk); n++; end
            n = 0;
            do begin @(negedge clk); n++; end while (!tq_en && n < 200);
            chk(n == p + 1, "R10", n, p + 1);
        end

        // R4 sleep waits for idle bus
        bus_idle = 1'b0;
        wr(5'd0, 8'h02);
        chk(sleep_ack == 0, "R4", sleep_ack, 0);
        bus_idle = 1'b1;
        @(negedge clk);
        chk(sleep_ack == 1, "R4", sleep_ack, 1);
        rd(5'd1, v); chk(v == 8'h02, "R8", v, 8'h02);

        // R5 activity ignored without wake-enable
        bus_activity = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(sleep_ack == 1, "R5", sleep_ack, 1);

        // R5 wake on activity with wake-enable, no re-entry
        wr(5'd0, 8'h06);
        @(negedge clk);
        chk(sleep_ack == 0, "R5", sleep_ack, 0);
        bus_activity = 1'b0;
        repeat (3) @(negedge clk);
        chk(sleep_ack == 0, "R5", sleep_ack, 0);

        // R3 removing the request, then re-entering sleep
        wr(5'd0, 8'h00);
        wr(5'd0, 8'h02);
        @(negedge clk);
        chk(sleep_ack == 1, "R4", sleep_ack, 1);

        // R6 init request overrides a running sleep
        wr(5'd0, 8'h03);
        @(negedge clk);
        chk(sleep_ack == 0 && init_ack == 1, "R6", {sleep_ack, init_ack}, 2'b01);
        repeat (3) @(negedge clk);
        chk(sleep_ack == 0, "R6", sleep_ack, 0);
        wr(5'd0, 8'h02);
        @(negedge clk);
        chk(init_ack == 0 && sleep_ack == 1, "R3", {sleep_ack, init_ack}, 2'b10);

        // R6 both requests from running
        wr(5'd0, 8'h00);
        @(negedge clk);
        chk(sleep_ack == 0, "R3", sleep_ack, 0);
        wr(5'd0, 8'h03);
        @(negedge clk);
        chk(sleep_ack == 0 && init_ack == 1, "R6", {sleep_ack, init_ack}, 2'b01);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule